// File: doc/BRIEF.md
# Completion-code interrupt pending controller

This block collects transfer-completion events from a DMA engine into a 64-bit pending vector and turns that vector into interrupt lines. Each event carries a 6-bit completion code chosen by software when the transfer was set up. The code is not tied to the channel number, so several channels can share one code and therefore one pending bit and one service routine. The event also says whether it is the final completion or an intermediate one. It marks its pending bit only when the matching final or intermediate interrupt enable of the transfer allows it.

Software sees the pending vector and the 64-bit enable vector as 32-bit lower and upper halves. It clears pending bits by writing ones, and it sets or clears enable bits through dedicated operations. Each of four shadow regions holds its own 64-bit access mask. One global line reports any pending bit whose enable is set. Each region line reports any such bit that the region's mask also admits. All outputs are levels.

Top module: `cmpl_irq_ctrl`

## Requirements
- R1: An accepted event with code n sets pending bit n one clock later. Bits 0..31 show on `pendLo[n]`, and bits 32..63 show on `pendHi[n-32]`; for example, code 0x21 sets `pendHi[1]`.
- R2: An event with `evtFinal`=1 is accepted only when `finalIntEn`=1. An event with `evtFinal`=0 is accepted only when `interIntEn`=1. A rejected event leaves the pending vector unchanged.
- R3: An event whose bit is already pending changes nothing, and no count is kept. A single clear removes the bit however many events hit it.
- R4: `wrOp`=1 clears pending bits: every 1 in `wrData` clears the matching bit of the lower half (`wrHi`=0) or the upper half (`wrHi`=1). Zero bits leave their pending bits as they are.
- R5: When an accepted event and a clear hit the same bit in the same cycle, the bit ends up set.
- R6: `wrOp`=2 ORs `wrData` into the enable half chosen by `wrHi`. `wrOp`=3 clears the enable bits where `wrData` is 1. The result shows on `enLo`/`enHi` one clock later.
- R7: `wrOp`=4 writes `wrData` into the half (`wrHi`) of the access mask of region `wrRegion`. `maskRdLo`/`maskRdHi` show the mask of region `rdRegion` without delay. `wrOp` values 0 and 5..7 change no state.
- R8: `irqGlobal` is high exactly when some bit is both pending and enabled. It follows the registered state with no extra delay.
- R9: `irqRegion[r]` is high exactly when some bit is pending, enabled and set in the access mask of region r. A region line never rises without `irqGlobal`.
- R10: After reset, all pending, enable and mask bits are zero and all interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| evtValid | input | 1 | Completion event strobe |
| evtCode | input | 6 | Completion code of the event |
| evtFinal | input | 1 | 1 = final completion, 0 = intermediate |
| finalIntEn | input | 1 | Transfer allows interrupts on final completion |
| interIntEn | input | 1 | Transfer allows interrupts on intermediate completion |
| wrOp | input | 3 | Register operation: 0 idle, 1 clear pending, 2 set enable, 3 clear enable, 4 write mask |
| wrHi | input | 1 | Selects the upper half for the operation |
| wrRegion | input | 2 | Region addressed by a mask write |
| wrData | input | 32 | Operation data |
| rdRegion | input | 2 | Region whose mask is shown |
| pendLo | output | 32 | Pending bits 0..31 |
| pendHi | output | 32 | Pending bits 32..63 |
| enLo | output | 32 | Enable bits 0..31 |
| enHi | output | 32 | Enable bits 32..63 |
| maskRdLo | output | 32 | Selected region mask bits 0..31 |
| maskRdHi | output | 32 | Selected region mask bits 32..63 |
| irqGlobal | output | 1 | Global interrupt level |
| irqRegion | output | 4 | Per-region interrupt levels |

## Verification
The hardest case to reach from the ports is an accepted event and a write-one-to-clear that land on the same pending bit in the same cycle. The stimulus places a code in the upper half, raises that bit, and then drives a second event with the same code together with a clear of that bit in one cycle. The bench expects the bit to stay set, and a second clear alone then removes it. Region lines need three independent vectors to line up. The bench therefore programs a mask half, an enable bit and an event separately, then removes only the enable and expects both the region line and the global line to fall.

// File: rtl/cmpl_irq_pkg.sv
package cmpl_irq_pkg;
  localparam int PEND_BITS   = 64;
  localparam int HALF_BITS   = PEND_BITS / 2;
  localparam int CODE_BITS   = $clog2(PEND_BITS);
  localparam int N_REGIONS   = 4;
  localparam int REGION_BITS = $clog2(N_REGIONS);
  localparam int OP_BITS     = 3;

  typedef enum logic [OP_BITS-1:0] {
    OP_IDLE     = 3'd0,
    OP_CLR_PEND = 3'd1,
    OP_EN_SET   = 3'd2,
    OP_EN_CLR   = 3'd3,
    OP_MASK_WR  = 3'd4
  } wrOp_e;

  typedef struct packed {
    logic                   setPend;
    logic [CODE_BITS-1:0]   code;
    logic                   clrPend;
    logic                   enSet;
    logic                   enClr;
    logic                   maskWr;
    logic                   hiHalf;
    logic [REGION_BITS-1:0] region;
  } ctlStrb_t;
endpackage

// File: rtl/cmpl_irq_ctl.sv
module cmpl_irq_ctl
  import cmpl_irq_pkg::*;
(
  input  logic                   evtValid,
  input  logic [CODE_BITS-1:0]   evtCode,
  input  logic                   evtFinal,
  input  logic                   finalIntEn,
  input  logic                   interIntEn,
  input  logic [OP_BITS-1:0]     wrOp,
  input  logic                   wrHi,
  input  logic [REGION_BITS-1:0] wrRegion,
  output ctlStrb_t               strb
);
  logic evtAllowed;

  // final events follow the final enable, all others the intermediate enable
  assign evtAllowed = evtFinal ? finalIntEn : interIntEn;

  always_comb begin
    strb         = '0;
    strb.setPend = evtValid && evtAllowed;
    strb.code    = evtCode;
    strb.hiHalf  = wrHi;
    strb.region  = wrRegion;
    case (wrOp_e'(wrOp))
      OP_CLR_PEND: strb.clrPend = 1'b1;
      OP_EN_SET:   strb.enSet   = 1'b1;
      OP_EN_CLR:   strb.enClr   = 1'b1;
      OP_MASK_WR:  strb.maskWr  = 1'b1;
      default:     ;
    endcase
  end
endmodule

// File: rtl/cmpl_irq_dp.sv
module cmpl_irq_dp
  import cmpl_irq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlStrb_t               strb,
  input  logic [HALF_BITS-1:0]   wrData,
  input  logic [REGION_BITS-1:0] rdRegion,
  output logic [PEND_BITS-1:0]   pendVec,
  output logic [PEND_BITS-1:0]   enVec,
  output logic [PEND_BITS-1:0]   maskRd,
  output logic                   irqGlobal,
  output logic [N_REGIONS-1:0]   irqRegion
);
  logic [PEND_BITS-1:0] pendQ, enQ;
  logic [N_REGIONS-1:0][PEND_BITS-1:0] maskQ;
  logic [PEND_BITS-1:0] setVec, dataVec, halfSel, clrVec, activeVec;

  assign setVec  = strb.setPend ? (PEND_BITS'(1) << strb.code) : '0;
  assign dataVec = strb.hiHalf ? {wrData, {HALF_BITS{1'b0}}}
                               : {{HALF_BITS{1'b0}}, wrData};
  assign halfSel = strb.hiHalf ? {{HALF_BITS{1'b1}}, {HALF_BITS{1'b0}}}
                               : {{HALF_BITS{1'b0}}, {HALF_BITS{1'b1}}};
  assign clrVec  = strb.clrPend ? dataVec : '0;

  // set is ORed after the clear so it wins on a collision
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= (pendQ & ~clrVec) | setVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           enQ <= '0;
    else if (strb.enSet) enQ <= enQ | dataVec;
    else if (strb.enClr) enQ <= enQ & ~dataVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskQ <= '0;
    else if (strb.maskWr) begin
      for (int r = 0; r < N_REGIONS; r++) begin
        if (strb.region == REGION_BITS'(r))
          maskQ[r] <= (maskQ[r] & ~halfSel) | dataVec;
      end
    end
  end

  assign activeVec = pendQ & enQ;
  assign irqGlobal = |activeVec;

  for (genvar g = 0; g < N_REGIONS; g++) begin : gRegion
    assign irqRegion[g] = |(activeVec & maskQ[g]);
  end

  assign pendVec = pendQ;
  assign enVec   = enQ;
  assign maskRd  = maskQ[rdRegion];
endmodule

// File: rtl/cmpl_irq_ctrl.sv
module cmpl_irq_ctrl
  import cmpl_irq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   evtValid,
  input  logic [CODE_BITS-1:0]   evtCode,
  input  logic                   evtFinal,
  input  logic                   finalIntEn,
  input  logic                   interIntEn,
  input  logic [OP_BITS-1:0]     wrOp,
  input  logic                   wrHi,
  input  logic [REGION_BITS-1:0] wrRegion,
  input  logic [HALF_BITS-1:0]   wrData,
  input  logic [REGION_BITS-1:0] rdRegion,
  output logic [HALF_BITS-1:0]   pendLo,
  output logic [HALF_BITS-1:0]   pendHi,
  output logic [HALF_BITS-1:0]   enLo,
  output logic [HALF_BITS-1:0]   enHi,
  output logic [HALF_BITS-1:0]   maskRdLo,
  output logic [HALF_BITS-1:0]   maskRdHi,
  output logic                   irqGlobal,
  output logic [N_REGIONS-1:0]   irqRegion
);
  ctlStrb_t strb;
  logic [PEND_BITS-1:0] pendVec, enVec, maskRd;

  cmpl_irq_ctl u_ctl (
    .evtValid(evtValid), .evtCode(evtCode), .evtFinal(evtFinal),
    .finalIntEn(finalIntEn), .interIntEn(interIntEn),
    .wrOp(wrOp), .wrHi(wrHi), .wrRegion(wrRegion), .strb(strb)
  );

  cmpl_irq_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdRegion(rdRegion),
    .pendVec(pendVec), .enVec(enVec), .maskRd(maskRd),
    .irqGlobal(irqGlobal), .irqRegion(irqRegion)
  );

  assign {pendHi, pendLo}     = pendVec;
  assign {enHi, enLo}         = enVec;
  assign {maskRdHi, maskRdLo} = maskRd;
endmodule

// File: rtl/cmpl_irq_chk.sv
module cmpl_irq_chk
  import cmpl_irq_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   evtValid,
  input logic [CODE_BITS-1:0]   evtCode,
  input logic                   evtFinal,
  input logic                   finalIntEn,
  input logic                   interIntEn,
  input logic [OP_BITS-1:0]     wrOp,
  input logic                   wrHi,
  input logic [REGION_BITS-1:0] wrRegion,
  input logic [HALF_BITS-1:0]   wrData,
  input logic [REGION_BITS-1:0] rdRegion,
  input logic [HALF_BITS-1:0]   pendLo,
  input logic [HALF_BITS-1:0]   pendHi,
  input logic [HALF_BITS-1:0]   enLo,
  input logic [HALF_BITS-1:0]   enHi,
  input logic [HALF_BITS-1:0]   maskRdLo,
  input logic [HALF_BITS-1:0]   maskRdHi,
  input logic                   irqGlobal,
  input logic [N_REGIONS-1:0]   irqRegion
);
  logic accepted;
  logic [PEND_BITS-1:0] pendAll;
  assign accepted = evtValid && (evtFinal ? finalIntEn : interIntEn);
  assign pendAll  = {pendHi, pendLo};

  // R1, R5: an accepted event leaves its bit set, even against a clear
  p_evt_sets_bit_r1: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> pendAll[$past(evtCode)]);

  // R2: without an accepted event or a clear the pending vector holds
  p_reject_holds_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!accepted && wrOp != 3'd1) |=> $stable(pendAll));

  // R4: a clear of the lower half with no event removes every written bit
  p_clr_lo_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrOp == 3'd1 && !wrHi && !accepted) |=> ((pendLo & $past(wrData)) == '0));

  // R6: enable set on the lower half turns on every written bit
  p_en_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrOp == 3'd2 && !wrHi) |=> ((enLo & $past(wrData)) == $past(wrData)));

  // R9: a region line implies the global line
  p_region_in_global_r9: assert property (@(posedge clk) disable iff (!rstN)
    (|irqRegion) |-> irqGlobal);

  // R8: the global line needs a bit that is pending and enabled
  p_global_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqGlobal |-> (|({pendHi, pendLo} & {enHi, enLo})));
endmodule

bind cmpl_irq_ctrl cmpl_irq_chk u_chk (.*);

// File: tb/cmpl_irq_ctrl_tb.sv
module cmpl_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evtValid = 1'b0, evtFinal = 1'b0, finalIntEn = 1'b0, interIntEn = 1'b0;
  logic [5:0] evtCode = '0;
  logic [2:0] wrOp = '0;
  logic wrHi = 1'b0;
  logic [1:0] wrRegion = '0, rdRegion = '0;
  logic [31:0] wrData = '0;
  logic [31:0] pendLo, pendHi, enLo, enHi, maskRdLo, maskRdHi;
  logic irqGlobal;
  logic [3:0] irqRegion;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmpl_irq_ctrl u_dut (.*);

  typedef struct {
    logic [31:0] pLo, pHi, eLo, eHi, mLo, mHi;
    logic        g;
    logic [3:0]  r;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int failures = 0;

  logic [63:0] pendM = '0, enM = '0;
  logic [63:0] maskM [4];

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic compare(expItem_t e);
    checks++;
    if (pendLo !== e.pLo || pendHi !== e.pHi || enLo !== e.eLo || enHi !== e.eHi ||
        maskRdLo !== e.mLo || maskRdHi !== e.mHi || irqGlobal !== e.g || irqRegion !== e.r) begin
      failures++;
      $display("FAIL %s: got pend=%h_%h en=%h_%h mask=%h_%h g=%b r=%b exp pend=%h_%h en=%h_%h mask=%h_%h g=%b r=%b",
               e.tag, pendHi, pendLo, enHi, enLo, maskRdHi, maskRdLo, irqGlobal, irqRegion,
               e.pHi, e.pLo, e.eHi, e.eLo, e.mHi, e.mLo, e.g, e.r);
    end
  endtask

  function automatic expItem_t modelItem(string tag);
    expItem_t e;
    logic [63:0] act, m;
    act = pendM & enM;
    m = maskM[rdRegion];
    e.pLo = pendM[31:0]; e.pHi = pendM[63:32];
    e.eLo = enM[31:0];   e.eHi = enM[63:32];
    e.mLo = m[31:0];     e.mHi = m[63:32];
    e.g = |act;
    for (int r = 0; r < 4; r++) e.r[r] = |(act & maskM[r]);
    e.tag = tag;
    return e;
  endfunction

  // driver: called at a falling edge, drives one cycle and queues the expectation
  task automatic step(input logic ev, input logic [5:0] code, input logic fin,
                      input logic fEn, input logic iEn, input logic [2:0] op,
                      input logic hi, input logic [1:0] rg, input logic [31:0] d,
                      input logic [1:0] rd, input string tag);
    logic [63:0] dv, setV;
    evtValid = ev; evtCode = code; evtFinal = fin; finalIntEn = fEn; interIntEn = iEn;
    wrOp = op; wrHi = hi; wrRegion = rg; wrData = d; rdRegion = rd;
    dv = hi ? {d, 32'h0} : {32'h0, d};
    setV = (ev && (fin ? fEn : iEn)) ? (64'd1 << code) : 64'd0;
    if (op == 3'd1) pendM = pendM & ~dv;
    pendM = pendM | setV;
    if (op == 3'd2) enM = enM | dv;
    if (op == 3'd3) enM = enM & ~dv;
    if (op == 3'd4) begin
      if (hi) maskM[rg][63:32] = d; else maskM[rg][31:0] = d;
    end
    expQ.push_back(modelItem(tag));
    @(negedge clk);
  endtask

  // monitor: compare just after each rising edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) compare(expQ.pop_front());
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout exp completion");
    report();
    $finish;
  end

  initial begin
    for (int r = 0; r < 4; r++) maskM[r] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    compare(modelItem("R10 reset state"));

    step(0, 0, 0, 0, 0, 3'd2, 0, 0, 32'hFFFF_FFFF, 0, "R6 enable set lo");
    step(0, 0, 0, 0, 0, 3'd2, 1, 0, 32'h0000_000A, 0, "R6 enable set hi");
    step(1, 6'd5, 1, 1, 0, 3'd0, 0, 0, 0, 0, "R1 R8 final event code 5");
    step(1, 6'h21, 0, 0, 1, 3'd0, 0, 0, 0, 0, "R1 intermediate code 0x21 to pendHi[1]");
    step(1, 6'h3F, 1, 0, 1, 3'd0, 0, 0, 0, 0, "R2 final rejected");
    step(1, 6'h10, 0, 1, 0, 3'd0, 0, 0, 0, 0, "R2 intermediate rejected");
    step(1, 6'd5, 1, 1, 1, 3'd0, 0, 0, 0, 0, "R3 repeat code no effect");
    step(0, 0, 0, 0, 0, 3'd1, 0, 0, 32'h0000_0020, 0, "R3 R4 single clear lo");
    step(1, 6'h21, 1, 1, 0, 3'd1, 1, 0, 32'h0000_0002, 0, "R5 set beats clear");
    step(0, 0, 0, 0, 0, 3'd1, 1, 0, 32'h0000_0002, 0, "R4 clear hi");
    step(0, 0, 0, 0, 0, 3'd4, 0, 2'd2, 32'hFFFF_0000, 2'd2, "R7 mask write region 2");
    step(1, 6'h14, 1, 1, 0, 3'd0, 0, 0, 0, 2'd2, "R9 region 2 line");
    step(0, 0, 0, 0, 0, 3'd3, 0, 0, 32'h0010_0000, 2'd2, "R6 R9 enable clear drops lines");
    step(0, 0, 0, 0, 0, 3'd4, 1, 2'd3, 32'h0000_0008, 2'd3, "R7 mask write region 3 hi");
    step(0, 0, 0, 0, 0, 3'd5, 1, 2'd3, 32'hFFFF_FFFF, 2'd3, "R7 op 5 ignored");
    step(0, 0, 0, 0, 0, 3'd7, 0, 2'd1, 32'hFFFF_FFFF, 2'd1, "R7 op 7 ignored");
    step(0, 0, 0, 0, 0, 3'd2, 1, 0, 32'h0000_0008, 2'd3, "R6 enable set hi bit 3");
    step(1, 6'h23, 0, 0, 1, 3'd0, 0, 0, 0, 2'd3, "R9 region 3 line");
    for (int c = 0; c < 64; c++)
      step(1, 6'(c), 1, 1, 1, 3'd0, 0, 0, 0, 2'(c % 4), "R1 code sweep");
    step(0, 0, 0, 0, 0, 3'd1, 0, 0, 32'hFFFF_FFFF, 0, "R4 clear all lo");
    step(0, 0, 0, 0, 0, 3'd1, 1, 0, 32'h5555_5555, 0, "R4 partial clear hi");
    step(0, 0, 0, 0, 0, 3'd1, 1, 0, 32'hFFFF_FFFF, 0, "R4 clear all hi");
    step(0, 0, 0, 0, 0, 3'd0, 0, 0, 0, 0, "R8 idle all low");
    repeat (3) @(negedge clk);
    report();
    $finish;
  end
endmodule